// File: doc/BRIEF.md
# Memory Hole Remap Address Translator

This block lets the processor reach the DRAM that sits behind the two low-memory holes, the video region starting at 0xA0000 and the option-ROM region starting at 0xD0000, by opening two 128 KB aliases for it above 1 MB. Every cycle it takes a 24-bit physical address, a 4-bit relocation base field and a high-shadow flag. It decides whether the address lands in one of the alias windows and, if so, produces the DRAM address behind that window.

The base field selects a 1 MB boundary. The first window starts at that boundary. The second window starts 128 KB above it. A base of zero turns both windows off. The second window is also turned off while high shadowing is active, because the DRAM behind it is then in use as shadow memory. The translation uses the lowest byte address of an access, so byte, word and doubleword accesses are handled the same way. Results are registered, so each result appears one clock after its inputs.

Top module: `remap_xlate`

## Requirements
- R1: While `rst` is high at a rising edge, the next outputs are `hit_o`=0, `win_o`=0 and `addr_o`=0.
- R2: Outputs are registered. The result for inputs present at rising edge N appears after edge N and does not change before edge N+1.
- R3: When `base_i` is 0, `hit_o` is 0 and `addr_o` equals the input address, for every address and every shadow setting.
- R4: With S = `base_i`×0x100000, an address A where S ≤ A < S+0x20000 gives `hit_o`=1, `win_o`=0 and `addr_o` = A − S + 0xA0000.
- R5: With `hi_shadow_i`=0, an address A where S+0x20000 ≤ A < S+0x40000 gives `hit_o`=1, `win_o`=1 and `addr_o` = A − S − 0x20000 + 0xD0000.
- R6: With `hi_shadow_i`=1, addresses in the second window miss and pass through unchanged. The first window is not affected.
- R7: An address outside both windows, including S−1 and S+0x40000, gives `hit_o`=0, `win_o`=0 and `addr_o` equal to the input address.
- R8: On a hit, `addr_o` lies in 0xA0000–0xBFFFF for window 0 and in 0xD0000–0xEFFFF for window 1.
- R9: A change of `base_i` or `hi_shadow_i` applies to the address presented in the same cycle. No earlier configuration is used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | 24 | Physical address, lowest byte of the access |
| base_i | input | 4 | Relocation base in 1 MB units; 0 disables remapping |
| hi_shadow_i | input | 1 | High shadowing active; suppresses window 1 |
| hit_o | output | 1 | Address fell in an enabled window (registered) |
| win_o | output | 1 | Window that hit: 0 or 1 (registered) |
| addr_o | output | 24 | Translated address on a hit, input address otherwise (registered) |

## Verification
Two events can fall in the same cycle: an address arrives in window 1, and the shadow flag or the base field changes. The bench provokes this by driving a window-1 address together with a rising shadow flag, and then together with a new base value. The expected result is computed from the new configuration only. Random stimulus also changes base and shadow on every cycle while the addresses cluster around the window edges. Each registered result is compared against a bench model that uses plain range tests and subtraction.

// File: rtl/remap_pkg.sv
package remap_pkg;
  localparam int ADDR_W     = 24;
  localparam int BASE_W     = 4;
  localparam int BASE_SHIFT = 20;
  localparam int WIN_LOG2   = 17;
  localparam int NWIN       = 2;
  localparam int WIN_ID_W   = (NWIN > 1) ? $clog2(NWIN) : 1;
  localparam logic [ADDR_W-1:0] PHYS_W0 = 24'h0A0000;
  localparam logic [ADDR_W-1:0] PHYS_W1 = 24'h0D0000;
endpackage

// File: rtl/remap_window.sv
module remap_window #(
  parameter int ADDR_W     = 24,
  parameter int BASE_W     = 4,
  parameter int BASE_SHIFT = 20,
  parameter int WIN_LOG2   = 17,
  parameter int IDX        = 0,
  parameter logic [ADDR_W-1:0] PHYS = '0
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BASE_W-1:0] base_i,
  input  logic              block_i,
  output logic              hit_o,
  output logic [ADDR_W-1:0] xaddr_o
);
  localparam int TAG_W = ADDR_W - WIN_LOG2;

  // Window start expressed in whole windows: base in 1 MB units plus index.
  logic [TAG_W-1:0] start_tag;
  assign start_tag = (TAG_W'(base_i) << (BASE_SHIFT - WIN_LOG2)) + TAG_W'(IDX);

  assign hit_o   = (base_i != '0) && !block_i &&
                   (addr_i[ADDR_W-1:WIN_LOG2] == start_tag);
  assign xaddr_o = PHYS + ADDR_W'(addr_i[WIN_LOG2-1:0]);
endmodule

// File: rtl/remap_select.sv
module remap_select #(
  parameter int ADDR_W   = 24,
  parameter int NWIN     = 2,
  parameter int WIN_ID_W = 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [NWIN-1:0]             hit_vec,
  input  logic [NWIN-1:0][ADDR_W-1:0] xaddr,
  output logic                        hit_o,
  output logic [WIN_ID_W-1:0]         win_o,
  output logic [ADDR_W-1:0]           addr_o
);
  logic                nx_hit;
  logic [WIN_ID_W-1:0] nx_win;
  logic [ADDR_W-1:0]   nx_addr;

  // Lowest-numbered window wins; windows never overlap, so this is only a tie rule.
  always_comb begin
    nx_hit  = 1'b0;
    nx_win  = '0;
    nx_addr = addr_i;
    for (int k = NWIN - 1; k >= 0; k--) begin
      if (hit_vec[k]) begin
        nx_hit  = 1'b1;
        nx_win  = WIN_ID_W'(k);
        nx_addr = xaddr[k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_o  <= 1'b0;
      win_o  <= '0;
      addr_o <= '0;
    end else begin
      hit_o  <= nx_hit;
      win_o  <= nx_win;
      addr_o <= nx_addr;
    end
  end

  // Windows are disjoint: at most one may claim an address.
  always_comb begin
    if (!rst) assert ($onehot0(hit_vec)) else $error("assert_single_window_R5");
  end
endmodule

// File: rtl/remap_xlate.sv
module remap_xlate #(
  parameter int ADDR_W     = remap_pkg::ADDR_W,
  parameter int BASE_W     = remap_pkg::BASE_W,
  parameter int BASE_SHIFT = remap_pkg::BASE_SHIFT,
  parameter int WIN_LOG2   = remap_pkg::WIN_LOG2,
  parameter int NWIN       = remap_pkg::NWIN,
  parameter int WIN_ID_W   = remap_pkg::WIN_ID_W,
  parameter logic [NWIN-1:0][ADDR_W-1:0] PHYS_BASES = {remap_pkg::PHYS_W1, remap_pkg::PHYS_W0},
  parameter logic [NWIN-1:0] SHADOW_MASK = 2'b10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [BASE_W-1:0]   base_i,
  input  logic                hi_shadow_i,
  output logic                hit_o,
  output logic [WIN_ID_W-1:0] win_o,
  output logic [ADDR_W-1:0]   addr_o
);
  localparam logic [ADDR_W-1:0] WIN_SIZE = ADDR_W'(1) << WIN_LOG2;

  logic [NWIN-1:0]             hit_vec;
  logic [NWIN-1:0][ADDR_W-1:0] xaddr;

  for (genvar k = 0; k < NWIN; k++) begin : g_win
    remap_window #(
      .ADDR_W(ADDR_W), .BASE_W(BASE_W), .BASE_SHIFT(BASE_SHIFT),
      .WIN_LOG2(WIN_LOG2), .IDX(k), .PHYS(PHYS_BASES[k])
    ) u_win (
      .addr_i (addr_i),
      .base_i (base_i),
      .block_i(hi_shadow_i & SHADOW_MASK[k]),
      .hit_o  (hit_vec[k]),
      .xaddr_o(xaddr[k])
    );
  end

  remap_select #(.ADDR_W(ADDR_W), .NWIN(NWIN), .WIN_ID_W(WIN_ID_W)) u_sel (
    .clk(clk), .rst(rst), .addr_i(addr_i), .hit_vec(hit_vec), .xaddr(xaddr),
    .hit_o(hit_o), .win_o(win_o), .addr_o(addr_o)
  );

  // One cycle out of reset, so the sampled inputs belong to a live cycle.
  logic armed;
  always_ff @(posedge clk) armed <= !rst;

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!hit_o && win_o == '0 && addr_o == '0));

  assert_base_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(base_i) == '0) |-> (!hit_o && addr_o == $past(addr_i)));

  assert_shadow_block_R6: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(hi_shadow_i)) |-> !(hit_o && win_o == WIN_ID_W'(1)));

  assert_miss_passthru_R7: assert property (@(posedge clk) disable iff (rst)
    (armed && !hit_o) |-> (addr_o == $past(addr_i) && win_o == '0));

  assert_hole_range_R8: assert property (@(posedge clk) disable iff (rst)
    hit_o |-> (addr_o >= PHYS_BASES[win_o] && addr_o < PHYS_BASES[win_o] + WIN_SIZE));

  assert_hold_between_edges_R2: assert property (@(posedge clk) disable iff (rst)
    (armed && $stable(addr_i) && $stable(base_i) && $stable(hi_shadow_i)
     && $past(armed)) |=> $stable(addr_o));
endmodule

// File: tb/tb_remap_xlate.sv
module tb_remap_xlate;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic [23:0] addr_i;
  logic [3:0]  base_i;
  logic        hi_shadow_i;
  logic        hit_o;
  logic [0:0]  win_o;
  logic [23:0] addr_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  remap_xlate dut (
    .clk(clk), .rst(rst), .addr_i(addr_i), .base_i(base_i),
    .hi_shadow_i(hi_shadow_i), .hit_o(hit_o), .win_o(win_o), .addr_o(addr_o)
  );

  // Model: {hit, win, addr}, built from range tests and subtraction.
  function automatic logic [25:0] model(logic [23:0] a, logic [3:0] b, logic sh);
    logic [24:0] s0, s1, aa;
    aa = {1'b0, a};
    s0 = 25'(b) * 25'h100000;
    s1 = s0 + 25'h20000;
    if (b != 0 && aa >= s0 && aa < s1)
      return {1'b1, 1'b0, 24'(aa - s0 + 25'hA0000)};
    if (b != 0 && !sh && aa >= s1 && aa < s1 + 25'h20000)
      return {1'b1, 1'b1, 24'(aa - s1 + 25'hD0000)};
    return {1'b0, 1'b0, a};
  endfunction

  task automatic compare(logic [25:0] exp, string req);
    checks++;
    if ({hit_o, win_o, addr_o} !== exp) begin
      errors++;
      $display("FAIL %s: got hit=%0b win=%0d addr=%06h, expected hit=%0b win=%0d addr=%06h",
               req, hit_o, win_o, addr_o, exp[25], exp[24], exp[23:0]);
    end
  endtask

  // Drive at a falling edge; the result is sampled at the next falling edge.
  task automatic run(logic [23:0] a, logic [3:0] b, logic sh, string req);
    addr_i = a; base_i = b; hi_shadow_i = sh;
    @(negedge clk);
    compare(model(a, b, sh), req);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [25:0] prev;
    void'($urandom(32'd20211));
    rst = 1'b1; addr_i = 24'h123456; base_i = 4'h3; hi_shadow_i = 1'b0;
    repeat (3) @(negedge clk);
    compare(26'h0, "R1");
    rst = 1'b0;

    // R4: window 0 edges
    run(24'h300000, 4'h3, 1'b0, "R4");
    run(24'h31FFFF, 4'h3, 1'b0, "R4");
    run(24'h30BEEF, 4'h3, 1'b1, "R4");
    // R5: window 1 edges
    run(24'h320000, 4'h3, 1'b0, "R5");
    run(24'h33FFFF, 4'h3, 1'b0, "R5");
    run(24'hF2ABCD, 4'hF, 1'b0, "R5");
    // R6: shadow suppresses window 1 only
    run(24'h325000, 4'h3, 1'b1, "R6");
    run(24'h33FFFF, 4'h3, 1'b1, "R6");
    // R7: just outside the windows
    run(24'h2FFFFF, 4'h3, 1'b0, "R7");
    run(24'h340000, 4'h3, 1'b0, "R7");
    run(24'h0A1234, 4'h3, 1'b0, "R7");
    // R3: base zero disables everything
    run(24'h000000, 4'h0, 1'b0, "R3");
    run(24'h030000, 4'h0, 1'b0, "R3");
    run(24'h010000, 4'h0, 1'b1, "R3");
    // R9: configuration changes in the same cycle as the address
    run(24'h520000, 4'h5, 1'b0, "R9");
    run(24'h520000, 4'h5, 1'b1, "R9");
    run(24'h520000, 4'h5, 1'b0, "R9");
    run(24'h520000, 4'h7, 1'b0, "R9");
    run(24'h700010, 4'h7, 1'b0, "R9");

    // R2: output holds until the next rising edge
    run(24'h410000, 4'h4, 1'b0, "R2");
    prev = model(24'h410000, 4'h4, 1'b0);
    addr_i = 24'h430000; base_i = 4'h4; hi_shadow_i = 1'b0;
    #1 compare(prev, "R2");
    @(negedge clk);
    compare(model(24'h430000, 4'h4, 1'b0), "R2");

    // R1 again: reset in the middle of traffic
    rst = 1'b1;
    @(negedge clk);
    compare(26'h0, "R1");
    rst = 1'b0;

    // Random traffic clustered around the window edges (R4 R5 R6 R7 R8)
    for (int i = 0; i < 600; i++) begin
      logic [3:0]  b;
      logic [23:0] a;
      int unsigned pick;
      b = 4'($urandom_range(0, 15));
      pick = $urandom_range(0, 3);
      a = {b, 20'h0} + 24'(pick * 32'h20000) + 24'($urandom_range(0, 32'h1FFFF));
      if ($urandom_range(0, 4) == 0) a = 24'($urandom);
      if ($urandom_range(0, 5) == 0) a = {b, 20'h0} - 24'd1;
      run(a, b, 1'($urandom_range(0, 1)), "R8");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule